// File: doc/BRIEF.md
# CPU Reset Conditioning and Start-up Sequencer

This block sits between the board-level reset pin and a CPU core. It qualifies the external active-high reset by its width. A pulse only takes effect once it has stayed high for a minimum number of clocks. Narrower pulses are discarded and reported on a one-cycle flag. While an accepted reset is present, the core is held in its internal reset. Once the pin falls, the core stays idle for a fixed start-up delay. After that, a fetch-enable level rises and the first opcode fetch may go out at the power-on address.

The sequencer also keeps the core's mode state. Every accepted reset returns the core to real address mode. Only a request from the running core can move it to protected mode, and only a later accepted reset can take it back. In real mode the four top address lines of the start address are forced low. The block also divides the input clock by two to give the core its internal phase, and that phase is realigned to zero on every accepted reset.

Top module: `rsq_startup`

## Requirements
- R1: When the reset input is sampled high on 16 consecutive rising clock edges, the pulse is accepted. From the cycle after the 16th such edge, the internal reset output is 1 and fetch-enable is 0. They stay that way while the input stays high.
- R2: A reset pulse sampled high on 1 to 15 consecutive edges changes nothing else in the block. The too-short flag is 1 for exactly one cycle, the cycle after the first edge that samples the input low again. Otherwise the flag is 0.
- R3: After an accepted pulse, call E0 the first edge that samples the input low. Fetch-enable rises, and the internal reset falls, in the cycle after edge E0+38. Both stay unchanged in between.
- R4: If the input is sampled high again during the start-up wait, the wait is restarted. Fetch-enable then rises in the cycle after edge F+38, where F is the first low-sampling edge after that re-assertion.
- R5: Fetch-enable is the inverse of the internal reset. It rises once per accepted reset and stays 1, through any number of too-short pulses, until the next accepted reset.
- R6: The mode output is 1 for real mode and 0 for protected mode. An accepted reset forces it to 1. A high on the protection request input at a rising edge moves it to 0 only while fetch-enable is 1. It then stays 0 until the next accepted reset. Requests made while the core is in reset or in the wait are ignored.
- R7: The start address output is 24'h0FFFF0 in real mode, with bits 23:20 at zero. It is 24'hFFFFF0 in protected mode.
- R8: The phase output is 0 in the cycle after an accepted reset edge and toggles on every rising clock edge otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ext_i | input | 1 | External reset pin, active high |
| prot_set_i | input | 1 | Request from the running core to enter protected mode |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| real_mode_o | output | 1 | 1 = real address mode, 0 = protected mode |
| fetch_en_o | output | 1 | Level permitting opcode fetches |
| fetch_addr_o | output | 24 | Address of the first opcode fetch |
| rst_short_o | output | 1 | One-cycle flag for a reset pulse that was too short |
| phase_o | output | 1 | Internal processor phase, input clock divided by two |

## Verification
The bench hits the width boundary from both sides, with pulses of 15 and exactly 16 clocks. A filter that is off by one would either accept the 15-clock pulse and drop fetch-enable, or miss the 16-clock one and leave the mode state untouched. A short re-assertion in the middle of the start-up wait checks that the delay starts over. A counter that only pauses, or one that ignores the pulse, would let fetch-enable rise too early. Protection requests are sent both during the wait and in the running state, so a mode register that is not gated would leave real mode while the core is still held idle. The phase is also checked right after acceptance to catch a divider that is never realigned.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [1:0] {
      SEQ_HOLD = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/rsq_width_filter.sv
module rsq_width_filter #(
   parameter int MIN_W = 16
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic accept_o,
   output logic release_o,
   output logic short_o
);
   localparam int CW = $clog2(MIN_W + 1);
   localparam logic [CW-1:0] FULL = CW'(MIN_W);
   localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

   logic [CW-1:0] hi_cnt;
   logic          short_q;

   always_ff @(posedge clk_i) begin
      if (!rst_i)
         hi_cnt <= '0;
      else if (hi_cnt != FULL)
         hi_cnt <= hi_cnt + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      short_q <= !rst_i && (hi_cnt != '0) && (hi_cnt < FULL);
   end

   assign accept_o  = rst_i && (hi_cnt == LAST);
   assign release_o = !rst_i && (hi_cnt == FULL);
   assign short_o   = short_q;

   a_r2_short_single: assert property (@(posedge clk_i) disable iff (rst_i)
      short_q |=> !short_q);

   a_r1_no_accept_when_full: assert property (@(posedge clk_i) disable iff (!rst_i)
      (hi_cnt == FULL) |=> !accept_o);

endmodule

// File: rtl/rsq_start_timer.sv
module rsq_start_timer
   import rsq_pkg::*;
#(
   parameter int DELAY = 38
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       accept_i,
   input  logic       release_i,
   output seq_state_e state_o
);
   localparam int WW = $clog2(DELAY + 1);
   localparam logic [WW-1:0] DONE = WW'(DELAY);

   seq_state_e    state_q;
   logic [WW-1:0] wcnt;

   always_ff @(posedge clk_i) begin
      if (accept_i) begin
         state_q <= SEQ_HOLD;
         wcnt    <= '0;
      end else begin
         case (state_q)
            SEQ_HOLD: begin
               if (release_i) begin
                  state_q <= SEQ_WAIT;
                  wcnt    <= WW'(1);
               end
            end
            SEQ_WAIT: begin
               if (rst_i)
                  wcnt <= '0;
               else if (wcnt == DONE)
                  state_q <= SEQ_RUN;
               else
                  wcnt <= wcnt + 1'b1;
            end
            SEQ_RUN: state_q <= SEQ_RUN;
            default: state_q <= SEQ_HOLD;
         endcase
      end
   end

   assign state_o = state_q;

   a_r3_wait_bounded: assert property (@(posedge clk_i) disable iff (accept_i)
      (state_q == SEQ_WAIT) |-> (wcnt <= DONE));

   a_r4_high_blocks_run: assert property (@(posedge clk_i) disable iff (accept_i)
      ((state_q == SEQ_WAIT) && rst_i) |=> (state_q == SEQ_WAIT));

endmodule

// File: rtl/rsq_phase_div.sv
module rsq_phase_div #(
   parameter int PHASE_W = 1
) (
   input  logic clk_i,
   input  logic resync_i,
   output logic phase_o
);
   generate
      if (PHASE_W == 1) begin : g_toggle
         logic ph_q;
         always_ff @(posedge clk_i) begin
            if (resync_i) ph_q <= 1'b0;
            else          ph_q <= !ph_q;
         end
         assign phase_o = ph_q;

         a_r8_phase_toggles: assert property (@(posedge clk_i) disable iff (resync_i)
            !resync_i |=> (ph_q != $past(ph_q)));
      end else begin : g_count
         logic [PHASE_W-1:0] ph_cnt;
         always_ff @(posedge clk_i) begin
            if (resync_i) ph_cnt <= '0;
            else          ph_cnt <= ph_cnt + 1'b1;
         end
         assign phase_o = ph_cnt[PHASE_W-1];
      end
   endgenerate

endmodule

// File: rtl/rsq_mode_reg.sv
module rsq_mode_reg (
   input  logic clk_i,
   input  logic clear_i,
   input  logic set_i,
   output logic prot_o
);
   logic prot_q;

   always_ff @(posedge clk_i) begin
      if (clear_i)    prot_q <= 1'b0;
      else if (set_i) prot_q <= 1'b1;
   end

   assign prot_o = prot_q;

   a_r6_sticky_prot: assert property (@(posedge clk_i) disable iff (clear_i)
      prot_q |=> prot_q);

endmodule

// File: rtl/rsq_startup.sv
module rsq_startup
   import rsq_pkg::*;
#(
   parameter int                 MIN_RST_CYC = 16,
   parameter int                 FETCH_DELAY = 38,
   parameter int                 ADDR_W      = 24,
   parameter int                 REAL_AW     = 20,
   parameter int                 PHASE_W     = 1,
   parameter logic [ADDR_W-1:0]  BOOT_ADDR   = 24'hFFFFF0
) (
   input  logic              clk_i,
   input  logic              rst_ext_i,
   input  logic              prot_set_i,
   output logic              core_rst_o,
   output logic              real_mode_o,
   output logic              fetch_en_o,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic              rst_short_o,
   output logic              phase_o
);
   generate
      if (MIN_RST_CYC < 2) begin : g_bad_width
         $error("MIN_RST_CYC must be at least 2");
      end
      if (FETCH_DELAY < 1) begin : g_bad_delay
         $error("FETCH_DELAY must be at least 1");
      end
      if (REAL_AW >= ADDR_W) begin : g_bad_addr
         $error("REAL_AW must be below ADDR_W");
      end
      if (PHASE_W < 1) begin : g_bad_phase
         $error("PHASE_W must be at least 1");
      end
   endgenerate

   logic       accept;
   logic       release_w;
   logic       prot;
   logic       seen_q;
   seq_state_e state;

   rsq_width_filter #(.MIN_W(MIN_RST_CYC)) u_filter (
      .clk_i     (clk_i),
      .rst_i     (rst_ext_i),
      .accept_o  (accept),
      .release_o (release_w),
      .short_o   (rst_short_o)
   );

   rsq_start_timer #(.DELAY(FETCH_DELAY)) u_timer (
      .clk_i     (clk_i),
      .rst_i     (rst_ext_i),
      .accept_i  (accept),
      .release_i (release_w),
      .state_o   (state)
   );

   rsq_phase_div #(.PHASE_W(PHASE_W)) u_phase (
      .clk_i    (clk_i),
      .resync_i (accept),
      .phase_o  (phase_o)
   );

   rsq_mode_reg u_mode (
      .clk_i   (clk_i),
      .clear_i (accept),
      .set_i   (prot_set_i && (state == SEQ_RUN)),
      .prot_o  (prot)
   );

   assign fetch_en_o  = (state == SEQ_RUN);
   assign core_rst_o  = !fetch_en_o;
   assign real_mode_o = !prot;

   genvar gi;
   generate
      for (gi = 0; gi < ADDR_W; gi++) begin : g_addr
         if (gi < REAL_AW) begin : g_low
            assign fetch_addr_o[gi] = BOOT_ADDR[gi];
         end else begin : g_high
            assign fetch_addr_o[gi] = BOOT_ADDR[gi] && prot;
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      seen_q <= seen_q | accept;
   end

   a_r1_accept_holds_core: assert property (@(posedge clk_i) disable iff (!seen_q)
      accept |=> (core_rst_o && !fetch_en_o && real_mode_o));

   a_r3_no_fetch_after_high: assert property (@(posedge clk_i) disable iff (!seen_q)
      $rose(fetch_en_o) |-> !$past(rst_ext_i));

   a_r5_fetch_stays: assert property (@(posedge clk_i) disable iff (!seen_q || accept)
      fetch_en_o |=> fetch_en_o);

   a_r6_real_in_reset: assert property (@(posedge clk_i) disable iff (!seen_q)
      core_rst_o |-> real_mode_o);

   a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!seen_q)
      real_mode_o |-> (fetch_addr_o[ADDR_W-1:REAL_AW] == '0));

endmodule

// File: tb/sim_rsq_startup.sv
`timescale 1ns/1ps
module sim_rsq_startup;
   localparam int MINW = 16;
   localparam int DLY  = 38;

   logic        clk = 1'b0;
   logic        rst_drv = 1'b0;
   logic        prot_drv = 1'b0;
   logic        core_rst, real_mode, fetch_en, rst_short, phase;
   logic [23:0] fetch_addr;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done  = 0;

   // reference model state
   int mh = 0, mst = 0, mw = 0;
   bit mph = 0, msh = 0, mpe = 0, mvalid = 0;

   always #2.5 clk = !clk;

   rsq_startup u0 (
      .clk_i        (clk),
      .rst_ext_i    (rst_drv),
      .prot_set_i   (prot_drv),
      .core_rst_o   (core_rst),
      .real_mode_o  (real_mode),
      .fetch_en_o   (fetch_en),
      .fetch_addr_o (fetch_addr),
      .rst_short_o  (rst_short),
      .phase_o      (phase)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 hold, 1 wait, 2 run
   always @(posedge clk) begin
      bit r, p, acc, rel, sh;
      r = rst_drv;
      p = prot_drv;
      acc = r && (mh == MINW - 1);
      rel = !r && (mh == MINW);
      sh  = !r && (mh > 0) && (mh < MINW);
      if (acc) mpe = 0;
      else if (mst == 2 && p) mpe = 1;
      mph = acc ? 1'b0 : !mph;
      if (acc) begin
         mst = 0; mw = 0;
      end else if (mst == 0) begin
         if (rel) begin mst = 1; mw = 1; end
      end else if (mst == 1) begin
         if (r) mw = 0;
         else if (mw == DLY) mst = 2;
         else mw = mw + 1;
      end
      mh = r ? ((mh == MINW) ? mh : mh + 1) : 0;
      msh = sh;
      if (acc) mvalid = 1;
   end

   always @(negedge clk) begin
      if (mvalid && !done) begin
         chk("R1 core_rst", core_rst, mst != 2);
         chk("R5 fetch_en", fetch_en, mst == 2);
         chk("R2 short", rst_short, msh);
         chk("R6 mode", real_mode, !mpe);
         chk("R7 addr", fetch_addr, mpe ? 24'hFFFFF0 : 24'h0FFFF0);
         chk("R8 phase", phase, mph);
      end
   end

   task automatic pulse(input int n);
      rst_drv = 1'b1;
      repeat (n) @(negedge clk);
      rst_drv = 1'b0;
   endtask

   task automatic wait_fetch(output int n);
      n = 0;
      while (!fetch_en && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n;
      bit ph0;
      repeat (3) @(negedge clk);
      // first accepted reset, long pulse
      pulse(20);
      // R1 reset state: rst dropped just now, outputs still from high phase
      chk("R1 reset core_rst", core_rst, 1);
      chk("R1 reset fetch", fetch_en, 0);
      chk("R6 reset real", real_mode, 1);
      chk("R7 reset addr", fetch_addr, 24'h0FFFF0);
      wait_fetch(n);
      chk("R3 start latency", n, DLY + 1);
      ph0 = phase;
      @(negedge clk);
      chk("R8 phase toggle", phase, !ph0);
      // short pulse in run
      pulse(5);
      @(negedge clk);
      chk("R2 short flag", rst_short, 1);
      chk("R5 fetch kept", fetch_en, 1);
      @(negedge clk);
      chk("R2 short one cycle", rst_short, 0);
      // 15-cycle boundary
      pulse(MINW - 1);
      @(negedge clk);
      chk("R2 fifteen ignored", fetch_en, 1);
      chk("R2 fifteen flagged", rst_short, 1);
      // protection request while running
      prot_drv = 1'b1;
      @(negedge clk);
      prot_drv = 1'b0;
      chk("R6 protected", real_mode, 0);
      chk("R7 protected addr", fetch_addr, 24'hFFFFF0);
      pulse(4);
      repeat (2) @(negedge clk);
      chk("R6 sticky", real_mode, 0);
      // exactly 16: accepted
      rst_drv = 1'b1;
      repeat (MINW) @(negedge clk);
      chk("R1 sixteen accepted", core_rst, 1);
      chk("R8 phase realigned", phase, 0);
      chk("R6 cleared", real_mode, 1);
      rst_drv = 1'b0;
      repeat (10) @(negedge clk);
      prot_drv = 1'b1;
      repeat (3) @(negedge clk);
      prot_drv = 1'b0;
      chk("R6 request in wait ignored", real_mode, 1);
      // glitch during wait restarts the count
      pulse(3);
      wait_fetch(n);
      chk("R4 restart latency", n, DLY + 1);
      chk("R7 real addr", fetch_addr, 24'h0FFFF0);
      repeat (5) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule